// File: doc/BRIEF.md
# Two-Client Quantum Bus Arbiter

This block decides which of two on-chip clients may drive the one bus that connects the card logic to an external MAC device. One client moves outgoing frames (transmit). The other drains incoming frames (receive). Each client raises a request, is answered with a grant, and can signal with a done pulse that it has finished early. Ownership is time-sliced. Each client holds the bus for at most its own quantum of bus clock cycles while the other client is waiting. After that the bus is taken away and passed to the waiting client.

The two quanta come from separate configuration inputs, so receive and transmit can be given different slice lengths. A quantum is sampled when a grant begins, or when it restarts. Receive wins whenever both clients ask at once from idle. After a forced or voluntary hand-over, ownership alternates: the client that did not just hold the bus is served first. Between any two owners there is exactly one cycle in which neither grant is high. A client with no competitor keeps the bus indefinitely, and its slice restarts each time it runs out.

Top module: `qarb_top`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), and whenever no client requests, both grants are low. A reset while a grant is held drops that grant at the same edge.
- R2: A grant goes high only at the clock edge that follows a cycle in which that client's request was high. From idle, a lone request is granted at the next edge.
- R3: When both requests are high in idle, rx_gnt is asserted and tx_gnt stays low.
- R4: tx_gnt and rx_gnt are never high together. Every change of owner has exactly one cycle with both grants low.
- R5: While the other client requests, an owner keeps its grant for exactly Q cycles. Q is the quantum input sampled at grant start. Its grant then drops at the next edge. A quantum value of 0 acts as 1.
- R6: tx_quantum and rx_quantum act independently: each client's slice length follows only its own input.
- R7: When receive loses the bus at quantum expiry and transmit is requesting, transmit is granted after the single gap cycle.
- R8: When transmit loses the bus at quantum expiry and receive is requesting, receive is granted after the single gap cycle.
- R9: If the owner's quantum expires while the other client does not request, the owner keeps its grant and a full new quantum starts at that edge.
- R10: When the owner's done is high at an edge, its grant drops at that edge. After the gap cycle the other client is granted if it requests. Otherwise the same client is granted again if it still requests.
- R11: When the owner's request is low at an edge, its grant drops at that edge, with the same follow-on choice as in R10.
- R12: A done pulse from the client that does not hold the grant has no effect on either grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_req | input | 1 | Transmit client requests the bus |
| tx_done | input | 1 | Transmit client releases the bus early |
| tx_quantum | input | QW | Transmit slice length in cycles (0 acts as 1) |
| rx_req | input | 1 | Receive client requests the bus |
| rx_done | input | 1 | Receive client releases the bus early |
| rx_quantum | input | QW | Receive slice length in cycles (0 acts as 1) |
| tx_gnt | output | 1 | Transmit client owns the bus |
| rx_gnt | output | 1 | Receive client owns the bus |

## Verification
The assertions assume that every input is a clean synchronous level, sampled at the rising edge. They also assume that the quantum inputs are held steady for as long as a client may load them. The stimulus changes requests, done pulses and quanta only on the falling edge. It alters the quantum inputs only while both clients are idle. The properties on hand-over and release do not depend on a client keeping its request high while it waits, so the stimulus withdraws and re-raises requests freely to reach the release cases.

// File: rtl/qarb_pkg.sv
// Package: shared types for the two-client quantum arbiter.
// Assumes client index 0 is transmit and index 1 is receive throughout.
package qarb_pkg;

    localparam int NCLI = 2;

    // Client identifiers; also used as indices into per-client vectors.
    typedef enum logic {
        CL_TX = 1'b0,
        CL_RX = 1'b1
    } client_t;

    // Arbiter states: idle, one per owner, and the hand-over gap.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TX   = 2'd1,
        ST_RX   = 2'd2,
        ST_GAP  = 2'd3
    } arb_state_t;

    // Ownership state that belongs to a client.
    function automatic arb_state_t owner_state(input client_t c);
        return (c == CL_RX) ? ST_RX : ST_TX;
    endfunction

    // The competing client.
    function automatic client_t other_client(input client_t c);
        return (c == CL_RX) ? CL_TX : CL_RX;
    endfunction

endpackage

// File: rtl/qarb_quantum_ctr.sv
// Module: per-client slice down-counter.
// Loads (quantum-1) when a grant starts or restarts; a quantum of 0 loads 0,
// so it behaves as a one-cycle slice. While the client holds the bus the
// counter steps down to zero and rests there; `expired` flags the last cycle.
// Assumes `load` and `run` come from the grant state machine.
module qarb_quantum_ctr #(
    parameter int QW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          run,
    input  logic [QW-1:0] quantum,
    output logic          expired
);

    localparam logic [QW-1:0] ZERO = '0;
    localparam logic [QW-1:0] ONE  = {{(QW-1){1'b0}}, 1'b1};

    logic [QW-1:0] remain;
    logic [QW-1:0] load_val;

    // Value loaded at slice start; zero quantum saturates to a one-cycle slice.
    always_comb begin
        load_val = (quantum == ZERO) ? ZERO : (quantum - ONE);
    end

    // Slice counter: reload on grant start, otherwise count down while owned.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= ZERO;
        end else if (load) begin
            remain <= load_val;
        end else if (run && (remain != ZERO)) begin
            remain <= remain - ONE;
        end
    end

    // Expiry flag: this is the last cycle of the current slice.
    always_comb begin
        expired = (remain == ZERO);
    end

endmodule

// File: rtl/qarb_fsm.sv
// Module: grant state machine for two clients.
// Picks the next owner, inserts one empty cycle on every hand-over, and
// tells each slice counter when to load and when to run. The grants are
// decoded straight from the state register, so they change only on clock edges.
// Assumes req/done are synchronous levels and `expired` comes from the
// client's own counter.
module qarb_fsm
    import qarb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCLI-1:0] req,
    input  logic [NCLI-1:0] done,
    input  logic [NCLI-1:0] expired,
    output logic [NCLI-1:0] gnt,
    output logic [NCLI-1:0] load,
    output logic [NCLI-1:0] run
);

    arb_state_t state, state_nxt;
    client_t    last, last_nxt;
    logic       restart;

    // Tie choice in the gap: serve the client that did not just own the bus.
    function automatic arb_state_t pick_after(input client_t prev,
                                              input logic [NCLI-1:0] r);
        client_t alt;
        alt = other_client(prev);
        if (r[alt]) begin
            return owner_state(alt);
        end else if (r[prev]) begin
            return owner_state(prev);
        end
        return ST_IDLE;
    endfunction

    // Next-state logic: release, preemption, slice restart and selection.
    always_comb begin
        client_t own;
        client_t oth;
        state_nxt = state;
        last_nxt  = last;
        restart   = 1'b0;
        own       = (state == ST_RX) ? CL_RX : CL_TX;
        oth       = other_client(own);
        unique case (state)
            ST_IDLE: begin
                if (req[CL_RX]) begin
                    state_nxt = ST_RX;
                end else if (req[CL_TX]) begin
                    state_nxt = ST_TX;
                end
            end
            ST_TX, ST_RX: begin
                if (done[own] || !req[own]) begin
                    state_nxt = ST_GAP;
                    last_nxt  = own;
                end else if (expired[own] && req[oth]) begin
                    state_nxt = ST_GAP;
                    last_nxt  = own;
                end else if (expired[own]) begin
                    restart = 1'b1;
                end
            end
            ST_GAP: begin
                state_nxt = pick_after(last, req);
            end
            default: begin
                state_nxt = ST_IDLE;
            end
        endcase
    end

    // State and last-owner registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            last  <= CL_TX;
        end else begin
            state <= state_nxt;
            last  <= last_nxt;
        end
    end

    // Per-client decode of grant, counter load and counter run.
    for (genvar c = 0; c < NCLI; c++) begin : g_cli
        localparam client_t CID = client_t'(c);
        always_comb begin
            gnt[c]  = (state == owner_state(CID));
            run[c]  = gnt[c];
            load[c] = (state_nxt == owner_state(CID)) &&
                      ((state != owner_state(CID)) || restart);
        end
    end

endmodule

// File: rtl/qarb_top.sv
// Module: two-client preemptive quantum arbiter for the shared MAC bus.
// Index 0 is the transmit client and index 1 is the receive client. The top
// packs the per-client ports into vectors, builds one slice counter per client,
// and drives the grants from the state machine.
// Assumes all inputs are synchronous to clk and that the quantum inputs are
// stable whenever a grant may begin.
module qarb_top
    import qarb_pkg::*;
#(
    parameter int QW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_req,
    input  logic          tx_done,
    input  logic [QW-1:0] tx_quantum,
    input  logic          rx_req,
    input  logic          rx_done,
    input  logic [QW-1:0] rx_quantum,
    output logic          tx_gnt,
    output logic          rx_gnt
);

    logic [NCLI-1:0]          req_v;
    logic [NCLI-1:0]          done_v;
    logic [NCLI-1:0]          exp_v;
    logic [NCLI-1:0]          gnt_v;
    logic [NCLI-1:0]          load_v;
    logic [NCLI-1:0]          run_v;
    logic [NCLI-1:0][QW-1:0]  quanta;

    // Gather the per-client ports into indexed vectors.
    always_comb begin
        req_v[CL_TX]  = tx_req;
        req_v[CL_RX]  = rx_req;
        done_v[CL_TX] = tx_done;
        done_v[CL_RX] = rx_done;
        quanta[CL_TX] = tx_quantum;
        quanta[CL_RX] = rx_quantum;
    end

    qarb_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req_v),
        .done    (done_v),
        .expired (exp_v),
        .gnt     (gnt_v),
        .load    (load_v),
        .run     (run_v)
    );

    for (genvar c = 0; c < NCLI; c++) begin : g_ctr
        qarb_quantum_ctr #(.QW(QW)) u_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (load_v[c]),
            .run     (run_v[c]),
            .quantum (quanta[c]),
            .expired (exp_v[c])
        );
    end

    // Drive the grant ports.
    always_comb begin
        tx_gnt = gnt_v[CL_TX];
        rx_gnt = gnt_v[CL_RX];
    end

endmodule

// File: rtl/qarb_chk.sv
// Module: property checker for qarb_top, attached with bind below.
// Watches only the top-level ports. Assumes inputs change away from the
// rising edge.
module qarb_chk #(
    parameter int QW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tx_req,
    input logic          tx_done,
    input logic [QW-1:0] tx_quantum,
    input logic          rx_req,
    input logic          rx_done,
    input logic [QW-1:0] rx_quantum,
    input logic          tx_gnt,
    input logic          rx_gnt
);

    AST_GNT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_gnt && rx_gnt)); // R4

    AST_TX_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_gnt) |-> !rx_gnt); // R4

    AST_RX_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_gnt) |-> !tx_gnt); // R4

    AST_TX_GNT_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_gnt) |-> $past(tx_req)); // R2

    AST_RX_GNT_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_gnt) |-> $past(rx_req)); // R2

    AST_TX_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_gnt && tx_done) |=> !tx_gnt); // R10

    AST_RX_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_gnt && rx_done) |=> !rx_gnt); // R10

    AST_TX_DROP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_gnt && !tx_req) |=> !tx_gnt); // R11

    AST_RX_DROP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_gnt && !rx_req) |=> !rx_gnt); // R11

    AST_IDLE_RX_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_gnt && !rx_gnt && tx_req && rx_req && $past(!tx_gnt && !rx_gnt))
        |=> !tx_gnt); // R3

endmodule

bind qarb_top qarb_chk #(.QW(QW)) u_qarb_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_req     (tx_req),
    .tx_done    (tx_done),
    .tx_quantum (tx_quantum),
    .rx_req     (rx_req),
    .rx_done    (rx_done),
    .rx_quantum (rx_quantum),
    .tx_gnt     (tx_gnt),
    .rx_gnt     (rx_gnt)
);

// File: tb/tb_qarb_top.sv
// Bench for qarb_top: a cycle table with tx quantum 3 and rx quantum 2,
// followed by directed reset and quantum tests.
module tb_qarb_top;

    localparam int QW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tx_req = 1'b0, tx_done = 1'b0, rx_req = 1'b0, rx_done = 1'b0;
    logic [QW-1:0] tx_quantum = 8'd3, rx_quantum = 8'd2;
    logic          tx_gnt, rx_gnt;
    int            n_chk = 0;
    int            n_bad = 0;

    always #5 clk = ~clk;

    qarb_top #(.QW(QW)) dut (
        .clk(clk), .rst_n(rst_n),
        .tx_req(tx_req), .tx_done(tx_done), .tx_quantum(tx_quantum),
        .rx_req(rx_req), .rx_done(rx_done), .rx_quantum(rx_quantum),
        .tx_gnt(tx_gnt), .rx_gnt(rx_gnt)
    );

    // Vector: [9:6] requirement number, [5] tx_req, [4] tx_done, [3] rx_req,
    // [2] rx_done, [1] expected tx_gnt, [0] expected rx_gnt after the edge.
    localparam int NV = 30;
    localparam logic [9:0] VEC [NV] = '{
        {4'd1,  6'b0000_00}, // R1 idle stays idle
        {4'd2,  6'b1000_10}, // R2 lone tx request granted
        {4'd5,  6'b1000_10},
        {4'd5,  6'b1010_10}, // rx starts waiting
        {4'd8,  6'b1010_00}, // R8 tx slice of 3 ends, gap
        {4'd8,  6'b1010_01}, // R8 rx follows
        {4'd6,  6'b1010_01},
        {4'd6,  6'b1010_00}, // R6 rx slice of 2 ends
        {4'd7,  6'b1010_10}, // R7 tx follows
        {4'd10, 6'b1110_00}, // R10 tx done releases early
        {4'd10, 6'b1010_01}, // R10 other client served
        {4'd9,  6'b0010_01},
        {4'd9,  6'b0010_01}, // R9 no rival, slice restarts
        {4'd9,  6'b1010_01}, // R9 full new slice still running
        {4'd9,  6'b1010_00},
        {4'd7,  6'b1000_10},
        {4'd11, 6'b0000_00}, // R11 tx drops request
        {4'd1,  6'b0000_00},
        {4'd3,  6'b1010_01}, // R3 both from idle, rx wins
        {4'd10, 6'b0011_00}, // R10 rx done
        {4'd10, 6'b0010_01}, // R10 same client regains
        {4'd11, 6'b1000_00}, // R11 rx drops request
        {4'd11, 6'b1000_10},
        {4'd11, 6'b0000_00},
        {4'd1,  6'b0000_00},
        {4'd12, 6'b0101_00}, // R12 done pulses with no owner
        {4'd2,  6'b0010_01},
        {4'd12, 6'b0110_01}, // R12 tx done ignored while rx owns
        {4'd11, 6'b0000_00},
        {4'd1,  6'b0000_00}
    };

    task automatic check(input string tag, input logic [1:0] act,
                         input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {tx_gnt,rx_gnt} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step(input logic tr, input logic td, input logic rr,
                        input logic rd);
        @(negedge clk);
        tx_req = tr; tx_done = td; rx_req = rr; rx_done = rd;
        @(posedge clk);
        #2;
    endtask

    // Both clients request continuously from idle; compare per-edge pattern.
    task automatic run_both(input string tag, input logic [1:0] pat [10]);
        for (int i = 0; i < 10; i++) begin
            step(1'b1, 1'b0, 1'b1, 1'b0);
            check(tag, {tx_gnt, rx_gnt}, pat[i]);
        end
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [1:0] pat [10];
        // R1 reset state
        repeat (2) @(posedge clk);
        #2;
        check("R1 in reset", {tx_gnt, rx_gnt}, 2'b00);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2]);
            check($sformatf("R%0d vec %0d", VEC[i][9:6], i),
                  {tx_gnt, rx_gnt}, VEC[i][1:0]);
        end

        // R1 reset while tx holds the bus
        step(1'b1, 1'b0, 1'b0, 1'b0);
        check("R2 tx granted before reset", {tx_gnt, rx_gnt}, 2'b10);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #2;
        check("R1 reset drops grant", {tx_gnt, rx_gnt}, 2'b00);
        @(negedge clk);
        rst_n = 1'b1;
        tx_req = 1'b0;
        @(posedge clk);

        // R6 different slices: tx 5, rx 1
        @(negedge clk);
        tx_quantum = 8'd5; rx_quantum = 8'd1;
        pat = '{2'b01, 2'b00, 2'b10, 2'b10, 2'b10, 2'b10, 2'b10, 2'b00,
                2'b01, 2'b00};
        run_both("R6 tx5 rx1", pat);

        // R5 zero quantum acts as one cycle
        @(negedge clk);
        tx_quantum = 8'd0; rx_quantum = 8'd0;
        pat = '{2'b01, 2'b00, 2'b10, 2'b00, 2'b01, 2'b00, 2'b10, 2'b00,
                2'b01, 2'b00};
        run_both("R5 zero quantum", pat);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule